// File: doc/BRIEF.md
# Command-Framed SPI Slave Frame Buffer

This block is an SPI target that trades fixed-size data frames with an external host through a small word-organised buffer. Every host transaction opens with an opcode byte. For buffer transfers the opcode is followed by an address byte, which the block ignores, and then by a run of data bytes. A buffer write fills the buffer from MOSI. A buffer read returns the buffer contents on MISO. Two further opcodes move a single status byte. One returns a locally supplied status value to the host, and the other hands a host-supplied byte to the local side.

The SPI pins are brought into the system clock domain through a short synchronizer, and all protocol logic runs on the system clock. This makes the block suitable for SCLK rates well below the system clock. On the local side there is a word-wide port into the same buffer and the two status bytes. There is also a set of sticky completion flags, each with its own enable and write-one-to-clear bit, which together drive a single interrupt line.

Top module: `spis_frame_slave`

## Requirements
- R1: Opcode 0x02 followed by an address byte and 32 data bytes stores data byte n in buffer word n/4, in byte lane n%4. The first byte of each group of four lands in bits [7:0].
- R2: Opcode 0x03 followed by an address byte returns 32 buffer bytes on MISO in the same byte order as R1. Each byte is sent most significant bit first, is sampled by the host on SCLK rising edges (mode 0), and is unaffected by whatever MOSI carries during the data phase.
- R3: The address byte of opcodes 0x02 and 0x03 has no effect: data always begins at buffer byte 0.
- R4: Opcode 0x04 followed by one byte returns the value on `rd_status` on MISO during that byte.
- R5: Opcode 0x01 followed by one byte loads that byte into `wr_status`.
- R6: `irq_flags` bit 0 means any frame done, bit 1 buffer write done, bit 2 buffer read done, bit 3 status write done and bit 4 status read done. When a frame of exactly the right length ends, bit 0 and the bit for that frame's kind become set on the third rising `clk` edge that samples `spi_cs_n` high.
- R7: Raising `spi_cs_n` before a frame is complete sets no flag. Bytes already written stay in the buffer, and the next frame starts again from its opcode byte.
- R8: A set flag stays set until a one is written to its `irq_clr` bit. If a flag is set and cleared in the same cycle, the set wins.
- R9: `irq` is high exactly when some flag is set whose `irq_en` bit is also set.
- R10: A local write stores `loc_wdata` into word `loc_addr`. `loc_rdata` shows word `loc_addr` one clock after the address is presented.
- R11: `spi_miso` is low while `spi_cs_n` is high.
- R12: After reset all flags, `irq`, `wr_status` and `spi_miso` are zero.
- R13: A frame with an opcode other than 0x01 to 0x04 changes neither the buffer nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from host, idle low |
| spi_cs_n | input | 1 | SPI chip select from host, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| loc_we | input | 1 | Local buffer word write strobe |
| loc_addr | input | 3 | Local buffer word index |
| loc_wdata | input | 32 | Local buffer write data |
| loc_rdata | output | 32 | Local buffer read data, one clock after address |
| rd_status | input | 8 | Status byte returned to the host by opcode 0x04 |
| wr_status | output | 8 | Status byte last written by the host with opcode 0x01 |
| irq_en | input | 5 | Per-flag interrupt enable |
| irq_clr | input | 5 | Per-flag write-one-to-clear |
| irq_flags | output | 5 | Sticky completion flags |
| irq | output | 1 | OR of enabled flags |

## Verification
The flag register has two writers: a frame completion derived from the chip-select rising edge, and the local write-one-to-clear input. Both can land on the same clock. The bench provokes this by timing a clear pulse so it is sampled on the exact edge where a status-write completion sets its flags, while older buffer-write flags are still pending. It then expects the older flags to be gone and the new ones present. A cycle-accurate model of the flags, fed by the same chip-select latency rule, is compared with the outputs on every clock, so any mismatch in priority or timing shows up at once.

// File: rtl/spis_pkg.sv
package spis_pkg;

   localparam logic [7:0] OPC_STS_WR = 8'h01;
   localparam logic [7:0] OPC_BUF_WR = 8'h02;
   localparam logic [7:0] OPC_BUF_RD = 8'h03;
   localparam logic [7:0] OPC_STS_RD = 8'h04;

   localparam int EVB_XFER = 0;
   localparam int EVB_BWR  = 1;
   localparam int EVB_BRD  = 2;
   localparam int EVB_SWR  = 3;
   localparam int EVB_SRD  = 4;
   localparam int EV_COUNT = 5;

   typedef enum logic [2:0] {
      FK_NONE,
      FK_BWR,
      FK_BRD,
      FK_SWR,
      FK_SRD
   } frame_kind_t;

   function automatic frame_kind_t decode_op(input logic [7:0] op);
      case (op)
         OPC_BUF_WR: return FK_BWR;
         OPC_BUF_RD: return FK_BRD;
         OPC_STS_WR: return FK_SWR;
         OPC_STS_RD: return FK_SRD;
         default:    return FK_NONE;
      endcase
   endfunction

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
   parameter int           W       = 1,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spis_sync needs at least two stages");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) st[s] <= RST_VAL;
      end else begin
         st[0] <= d;
         for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/spis_buffer.sv
module spis_buffer #(
   parameter int  DATA_BYTES = 32,
   parameter bit  RD_REG     = 1'b1,
   localparam int WORDS      = DATA_BYTES / 4,
   localparam int AW         = $clog2(WORDS),
   localparam int IDX_W      = $clog2(DATA_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             loc_we,
   input  logic [AW-1:0]    loc_addr,
   input  logic [31:0]      loc_wdata,
   output logic [31:0]      loc_rdata,
   input  logic             spi_we,
   input  logic [IDX_W-1:0] spi_idx,
   input  logic [7:0]       spi_wdata,
   output logic [7:0]       spi_rdata
);

   logic [31:0] mem [WORDS];

   // Local word write first, a same-cycle serial byte then overrides its lane.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      end else begin
         for (int w = 0; w < WORDS; w++) begin
            if (loc_we && loc_addr == AW'(w)) mem[w] <= loc_wdata;
            if (spi_we && spi_idx[IDX_W-1:2] == AW'(w))
               mem[w][8*spi_idx[1:0] +: 8] <= spi_wdata;
         end
      end
   end

   assign spi_rdata = mem[spi_idx[IDX_W-1:2]][8*spi_idx[1:0] +: 8];

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) loc_rdata <= '0;
         else        loc_rdata <= mem[loc_addr];
      end
   end else begin : g_rd_comb
      assign loc_rdata = mem[loc_addr];
   end

endmodule

// File: rtl/spis_irq.sv
module spis_irq #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] en,
   output logic [N-1:0] flags,
   output logic         irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr) | evt;
   end

   assign irq = |(flags & en);

endmodule

// File: rtl/spis_engine.sv
module spis_engine
   import spis_pkg::*;
#(
   parameter int  DATA_BYTES = 32,
   parameter int  HDR_BYTES  = 2,
   localparam int IDX_W      = $clog2(DATA_BYTES),
   localparam int CNT_W      = $clog2(HDR_BYTES + DATA_BYTES + 2)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sclk_s,
   input  logic                cs_n_s,
   input  logic                mosi_s,
   input  logic [7:0]          rd_status,
   input  logic [7:0]          buf_rdata,
   output logic [IDX_W-1:0]    buf_idx,
   output logic                buf_we,
   output logic [7:0]          buf_wdata,
   output logic [7:0]          wr_status,
   output logic [EV_COUNT-1:0] evt,
   output logic                miso
);

   localparam logic [CNT_W-1:0] HDR_C = CNT_W'(HDR_BYTES);
   localparam logic [CNT_W-1:0] LEN_C = CNT_W'(HDR_BYTES + DATA_BYTES);
   localparam logic [CNT_W-1:0] STS_C = CNT_W'(2);
   localparam logic [CNT_W-1:0] MAX_C = CNT_W'(HDR_BYTES + DATA_BYTES + 1);

   logic             sclk_q, cs_q;
   logic [2:0]       bit_cnt;
   logic [CNT_W-1:0] byte_cnt;
   logic [6:0]       rx_sh;
   logic [7:0]       tx_sh;
   frame_kind_t      kind;

   logic             rise, fall, start, stop, byte_done, in_data;
   logic [7:0]       rx_byte, tx_load;
   logic [CNT_W-1:0] flen;

   assign rise      = sclk_s & ~sclk_q & ~cs_n_s;
   assign fall      = ~sclk_s & sclk_q & ~cs_n_s;
   assign start     = ~cs_n_s & cs_q;
   assign stop      = cs_n_s & ~cs_q;
   assign rx_byte   = {rx_sh, mosi_s};
   assign byte_done = rise && (bit_cnt == 3'd7);
   assign in_data   = (byte_cnt >= HDR_C) && (byte_cnt < LEN_C);

   assign buf_idx   = IDX_W'(byte_cnt - HDR_C);
   assign buf_we    = byte_done && (kind == FK_BWR) && in_data;
   assign buf_wdata = rx_byte;

   always_comb begin
      if (kind == FK_BRD && in_data)                        tx_load = buf_rdata;
      else if (kind == FK_SRD && byte_cnt == CNT_W'(1))     tx_load = rd_status;
      else                                                  tx_load = 8'h00;
   end

   always_comb begin
      case (kind)
         FK_BWR, FK_BRD: flen = LEN_C;
         FK_SWR, FK_SRD: flen = STS_C;
         default:        flen = '0;
      endcase
   end

   always_comb begin
      evt = '0;
      if (stop && bit_cnt == 3'd0 && kind != FK_NONE && byte_cnt == flen) begin
         evt[EVB_XFER] = 1'b1;
         case (kind)
            FK_BWR:  evt[EVB_BWR] = 1'b1;
            FK_BRD:  evt[EVB_BRD] = 1'b1;
            FK_SWR:  evt[EVB_SWR] = 1'b1;
            FK_SRD:  evt[EVB_SRD] = 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q    <= 1'b0;
         cs_q      <= 1'b1;
         bit_cnt   <= '0;
         byte_cnt  <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         kind      <= FK_NONE;
         miso      <= 1'b0;
         wr_status <= '0;
      end else begin
         sclk_q <= sclk_s;
         cs_q   <= cs_n_s;
         if (start) begin
            bit_cnt  <= '0;
            byte_cnt <= '0;
            kind     <= FK_NONE;
            tx_sh    <= '0;
            miso     <= 1'b0;
         end
         if (stop) miso <= 1'b0;
         if (rise) begin
            rx_sh   <= rx_byte[6:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (byte_done) begin
               if (byte_cnt != MAX_C) byte_cnt <= byte_cnt + 1'b1;
               if (byte_cnt == '0) kind <= decode_op(rx_byte);
               if (kind == FK_SWR && byte_cnt == CNT_W'(1)) wr_status <= rx_byte;
            end
         end
         if (fall) begin
            if (bit_cnt == 3'd0) begin
               miso  <= tx_load[7];
               tx_sh <= {tx_load[6:0], 1'b0};
            end else begin
               miso  <= tx_sh[7];
               tx_sh <= {tx_sh[6:0], 1'b0};
            end
         end
      end
   end

endmodule

// File: rtl/spis_frame_slave.sv
module spis_frame_slave
   import spis_pkg::*;
#(
   parameter int  DATA_BYTES  = 32,
   parameter int  SYNC_STAGES = 2,
   parameter bit  LOC_RD_REG  = 1'b1,
   localparam int AW          = $clog2(DATA_BYTES / 4)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                spi_sclk,
   input  logic                spi_cs_n,
   input  logic                spi_mosi,
   output logic                spi_miso,
   input  logic                loc_we,
   input  logic [AW-1:0]       loc_addr,
   input  logic [31:0]         loc_wdata,
   output logic [31:0]         loc_rdata,
   input  logic [7:0]          rd_status,
   output logic [7:0]          wr_status,
   input  logic [EV_COUNT-1:0] irq_en,
   input  logic [EV_COUNT-1:0] irq_clr,
   output logic [EV_COUNT-1:0] irq_flags,
   output logic                irq
);

   localparam int IDX_W = $clog2(DATA_BYTES);

   if (DATA_BYTES < 8 || (DATA_BYTES & (DATA_BYTES - 1)) != 0) begin : g_bad_size
      $error("DATA_BYTES must be a power of two of at least 8");
   end

   logic [2:0]          pins_s;
   logic [IDX_W-1:0]    buf_idx;
   logic                buf_we;
   logic [7:0]          buf_wdata, buf_rdata;
   logic [EV_COUNT-1:0] evt;

   spis_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_cs_n, spi_sclk, spi_mosi}),
      .q     (pins_s)
   );

   spis_engine #(.DATA_BYTES(DATA_BYTES), .HDR_BYTES(2)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (pins_s[1]),
      .cs_n_s    (pins_s[2]),
      .mosi_s    (pins_s[0]),
      .rd_status (rd_status),
      .buf_rdata (buf_rdata),
      .buf_idx   (buf_idx),
      .buf_we    (buf_we),
      .buf_wdata (buf_wdata),
      .wr_status (wr_status),
      .evt       (evt),
      .miso      (spi_miso)
   );

   spis_buffer #(.DATA_BYTES(DATA_BYTES), .RD_REG(LOC_RD_REG)) u_buffer (
      .clk       (clk),
      .rst_n     (rst_n),
      .loc_we    (loc_we),
      .loc_addr  (loc_addr),
      .loc_wdata (loc_wdata),
      .loc_rdata (loc_rdata),
      .spi_we    (buf_we),
      .spi_idx   (buf_idx),
      .spi_wdata (buf_wdata),
      .spi_rdata (buf_rdata)
   );

   spis_irq #(.N(EV_COUNT)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt),
      .clr   (irq_clr),
      .en    (irq_en),
      .flags (irq_flags),
      .irq   (irq)
   );

endmodule

// File: rtl/spis_frame_slave_chk.sv
module spis_frame_slave_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       spi_cs_n,
   input logic       spi_miso,
   input logic [4:0] irq_clr,
   input logic [4:0] irq_flags,
   input logic       irq
);

   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R8: a flag not being cleared keeps its value
   p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((irq_flags & $past(irq_flags & ~irq_clr)) == $past(irq_flags & ~irq_clr)));

   // R6: a newly set kind flag always comes with the any-frame flag
   p_xfer_with_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst != 2'd0 && |(irq_flags[4:1] & ~$past(irq_flags[4:1]))) |-> irq_flags[0]);

   // R6: at most one kind flag becomes set at a time
   p_one_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst != 2'd0) |-> $onehot0(irq_flags[4:1] & ~$past(irq_flags[4:1])));

   // R6: a flag only rises after chip select was seen high two edges earlier
   p_flag_after_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2 && |(irq_flags & ~$past(irq_flags))) |-> $past(spi_cs_n, 2));

   // R11: MISO is low once chip select has been high for four samples
   p_miso_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
      |-> !spi_miso);

   // R9: no flag set means no interrupt
   p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flags == 5'd0) |-> !irq);

endmodule

bind spis_frame_slave spis_frame_slave_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .spi_cs_n  (spi_cs_n),
   .spi_miso  (spi_miso),
   .irq_clr   (irq_clr),
   .irq_flags (irq_flags),
   .irq       (irq)
);

// File: tb/tb_spis_frame_slave.sv
`timescale 1ns/1ps
module tb_spis_frame_slave;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic        miso;
   logic        loc_we = 1'b0;
   logic [2:0]  loc_addr = '0;
   logic [31:0] loc_wdata = '0, loc_rdata;
   logic [7:0]  rd_status = 8'h00, wr_status;
   logic [4:0]  irq_en = '0, irq_clr = '0, irq_flags;
   logic        irq;

   int n_chk = 0, n_fail = 0;

   logic [7:0] mbuf [32];
   logic [4:0] mflags, pend_evt = '0;
   logic       b1, b2, b3;

   spis_frame_slave dut (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .spi_miso(miso), .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
      .loc_rdata(loc_rdata), .rd_status(rd_status), .wr_status(wr_status),
      .irq_en(irq_en), .irq_clr(irq_clr), .irq_flags(irq_flags), .irq(irq)
   );

   always #5 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Flag model: event seen on the third edge that samples cs_n high (R6, R8)
   always @(posedge clk) begin
      if (!rst_n) begin
         b1 <= 1'b1; b2 <= 1'b1; b3 <= 1'b1; mflags <= '0;
      end else begin
         b1 <= cs_n; b2 <= b1; b3 <= b2;
         mflags <= (mflags & ~irq_clr) | ((b2 && !b3) ? pend_evt : 5'd0);
      end
   end

   always @(posedge clk) begin
      if (rst_n) begin
         chk(irq_flags == mflags, "R6/R8 flags per clock", {27'd0, irq_flags}, {27'd0, mflags});
         chk(irq == |(mflags & irq_en), "R9 irq per clock", {31'd0, irq}, {31'd0, |(mflags & irq_en)});
      end
   end

   task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         mosi = tx[i];
         repeat (8) @(negedge clk);
         rx[i] = miso;
         sclk = 1'b1;
         repeat (8) @(negedge clk);
         sclk = 1'b0;
      end
   endtask

   task automatic frame_open();
      @(negedge clk);
      cs_n = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic frame_close(input logic [4:0] ev);
      repeat (8) @(negedge clk);
      pend_evt = ev;
      cs_n = 1'b1;
      mosi = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   task automatic buf_write(input logic [7:0] addr_byte, input logic [7:0] base);
      logic [7:0] rx;
      frame_open();
      xfer_byte(8'h02, rx);
      xfer_byte(addr_byte, rx);
      for (int n = 0; n < 32; n++) begin
         xfer_byte(base + 8'(n), rx);
         mbuf[n] = base + 8'(n);
      end
      frame_close(5'b00011);
   endtask

   task automatic buf_read(input logic [7:0] fill, input string tag);
      logic [7:0] rx;
      frame_open();
      xfer_byte(8'h03, rx);
      xfer_byte(8'h00, rx);
      for (int n = 0; n < 32; n++) begin
         xfer_byte(fill, rx);
         chk(rx == mbuf[n], tag, {24'd0, rx}, {24'd0, mbuf[n]});
      end
      frame_close(5'b00101);
   endtask

   task automatic local_write(input int w, input logic [31:0] d);
      @(negedge clk);
      loc_we = 1'b1; loc_addr = 3'(w); loc_wdata = d;
      @(negedge clk);
      loc_we = 1'b0;
      for (int l = 0; l < 4; l++) mbuf[4*w+l] = d[8*l +: 8];
   endtask

   task automatic local_check(input int w, input string tag);
      logic [31:0] e;
      e = {mbuf[4*w+3], mbuf[4*w+2], mbuf[4*w+1], mbuf[4*w]};
      @(negedge clk);
      loc_addr = 3'(w);
      @(negedge clk);
      chk(loc_rdata == e, tag, loc_rdata, e);
   endtask

   task automatic clear_all();
      @(negedge clk); irq_clr = 5'h1F;
      @(negedge clk); irq_clr = 5'h00;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] rx;
      for (int n = 0; n < 32; n++) mbuf[n] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(irq_flags == 5'd0, "R12 flags reset", {27'd0, irq_flags}, 0);
      chk(irq == 1'b0, "R12 irq reset", {31'd0, irq}, 0);
      chk(wr_status == 8'h00, "R12 wr_status reset", {24'd0, wr_status}, 0);
      chk(miso == 1'b0, "R12 miso reset", {31'd0, miso}, 0);
      irq_en = 5'h1F;

      // R1: full buffer write, lane order
      buf_write(8'h00, 8'h40);
      for (int w = 0; w < 8; w++) local_check(w, "R1 buffer word after write");
      chk(irq_flags == 5'b00011, "R6 write done flags", {27'd0, irq_flags}, 32'h3);
      chk(irq == 1'b1, "R9 irq with flags", {31'd0, irq}, 1);
      clear_all();
      chk(irq_flags == 5'd0, "R8 clear", {27'd0, irq_flags}, 0);

      // R10 local write, then R2 read back on MISO with lane order
      local_write(3, 32'hA1B2C3D4);
      local_check(3, "R10 local write readback");
      buf_read(8'h00, "R2 read byte");
      chk(irq_flags == 5'b00101, "R6 read done flags", {27'd0, irq_flags}, 32'h5);
      chk(miso == 1'b0, "R11 miso idle", {31'd0, miso}, 0);
      clear_all();

      // R3: nonzero address still lands at byte 0
      buf_write(8'h5A, 8'hC0);
      local_check(0, "R3 address ignored word0");
      local_check(7, "R3 address ignored word7");
      clear_all();

      // R2: MOSI ones during read data do not disturb output or buffer
      buf_read(8'hFF, "R2 read with MOSI high");
      local_check(0, "R2 buffer unchanged by read");
      clear_all();

      // R4: status read
      rd_status = 8'h8A;
      frame_open();
      xfer_byte(8'h04, rx);
      xfer_byte(8'h00, rx);
      chk(rx == 8'h8A, "R4 status byte", {24'd0, rx}, 32'h8A);
      frame_close(5'b10001);
      chk(irq_flags == 5'b10001, "R6 status read flags", {27'd0, irq_flags}, 32'h11);
      clear_all();

      // R5: status write
      frame_open();
      xfer_byte(8'h01, rx);
      xfer_byte(8'h99, rx);
      frame_close(5'b01001);
      chk(wr_status == 8'h99, "R5 status write", {24'd0, wr_status}, 32'h99);
      chk(irq_flags == 5'b01001, "R6 status write flags", {27'd0, irq_flags}, 32'h9);
      clear_all();

      // R7: abort mid-frame
      frame_open();
      xfer_byte(8'h02, rx);
      xfer_byte(8'h00, rx);
      for (int n = 0; n < 5; n++) begin
         xfer_byte(8'hE0 + 8'(n), rx);
         mbuf[n] = 8'hE0 + 8'(n);
      end
      frame_close(5'b00000);
      chk(irq_flags == 5'd0, "R7 no flag on abort", {27'd0, irq_flags}, 0);
      local_check(0, "R7 bytes kept word0");
      local_check(1, "R7 bytes kept word1");
      frame_open();
      xfer_byte(8'h01, rx);
      xfer_byte(8'h3C, rx);
      frame_close(5'b01001);
      chk(wr_status == 8'h3C, "R7 fresh frame after abort", {24'd0, wr_status}, 32'h3C);
      clear_all();

      // R13: unknown opcode
      frame_open();
      for (int n = 0; n < 34; n++) xfer_byte((n == 0) ? 8'h07 : 8'h11, rx);
      frame_close(5'b00000);
      chk(irq_flags == 5'd0, "R13 no flag unknown op", {27'd0, irq_flags}, 0);
      local_check(0, "R13 buffer unchanged word0");
      local_check(2, "R13 buffer unchanged word2");

      // R8: clear and set on the same edge, older flags pending
      buf_write(8'h00, 8'h20);
      chk(irq_flags == 5'b00011, "R8 pending flags before collision", {27'd0, irq_flags}, 32'h3);
      frame_open();
      xfer_byte(8'h01, rx);
      xfer_byte(8'h5C, rx);
      repeat (8) @(negedge clk);
      pend_evt = 5'b01001;
      cs_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      irq_clr = 5'h1F;
      @(negedge clk);
      irq_clr = 5'h00;
      chk(irq_flags == 5'b01001, "R8 set wins over clear", {27'd0, irq_flags}, 32'h9);
      repeat (4) @(negedge clk);
      chk(irq_flags == 5'b01001, "R8 flags sticky", {27'd0, irq_flags}, 32'h9);

      // R9: enable masking
      irq_en = 5'h00;
      @(negedge clk);
      chk(irq == 1'b0, "R9 masked", {31'd0, irq}, 0);
      irq_en = 5'b01000;
      @(negedge clk);
      chk(irq == 1'b1, "R9 single enable", {31'd0, irq}, 1);
      irq_en = 5'b00110;
      @(negedge clk);
      chk(irq == 1'b0, "R9 enable on clear bits", {31'd0, irq}, 0);

      repeat (4) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule